// File: doc/BRIEF.md
# Clock Page Replacement Engine

This block chooses which of a fixed set of physical frames should be evicted next, following the second-chance (clock) policy. Each frame owns one referenced flag, and a rotating hand points at the frame to be inspected next. Whenever a frame is touched, the surrounding logic reports the frame index on the access-notify port, which raises that frame's flag.

When a replacement is requested, the engine walks forward from the hand and inspects one frame per clock cycle. Each frame whose flag is raised gets its flag lowered and is passed over. The first frame found with a lowered flag becomes the victim. The engine then reports that frame, raises its flag because a fresh page is about to occupy it, and moves the hand one step past it. If every flag is raised, one full lap lowers all of them and the victim is the frame where the walk began. In that case the policy behaves as plain first-in first-out.

Top module: `clock_repl`

## Requirements
- R1: After reset, busy and done are 0, victimFrame is 0, every referenced flag is clear and the hand points at frame 0, so the first request picks frame 0 after one inspection.
- R2: A cycle with accessValid high raises the flag of frame accessFrame. An index of NUM_FRAMES or more changes nothing.
- R3: During a search, one frame is inspected per cycle at the hand. A raised flag is lowered and the hand moves to the next frame.
- R4: The first inspected frame with a lowered flag becomes the victim. done is high for exactly one cycle, with victimFrame holding that index, and victimFrame keeps its value until the next done.
- R5: After a pick, the hand points at the frame after the victim, wrapping from NUM_FRAMES-1 to 0.
- R6: When every flag is raised, the victim is the frame where the hand started, and done rises NUM_FRAMES+1 cycles after the edge that accepts the request.
- R7: A request is accepted only while busy is low. busy is high from the cycle after acceptance up to the cycle done rises, and busy and done are never high together. A request made while busy has no effect.
- R8: If an access notify targets the frame whose flag the search lowers in that same cycle, the flag stays raised.
- R9: The victim's flag is raised when it is picked, so a later lap passes over it once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| accessValid | input | 1 | Access-notify strobe |
| accessFrame | input | IDX_W | Frame that was touched |
| reqValid | input | 1 | Request a victim search |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse: victimFrame is valid |
| victimFrame | output | IDX_W | Index of the chosen frame |

## Verification
Several flag patterns are used, and each separates a different fault:
- All flags clear: shows the one-inspection path and the hand advancing past each victim.
- A run of raised flags ahead of the hand: shows that flags are lowered as the walk passes and that the latency counts each skipped frame.
- All flags raised: shows the first-in first-out fallback and the worst-case latency of NUM_FRAMES+1.
- An access notify aimed at the frame being lowered, together with a walk that crosses the wrap point: shows the access taking priority and the hand wrapping correctly. The frame kept by the collision is then passed over on the next lap, which makes the kept flag visible as a later victim index.

A behavioural model is compared against busy, done and victimFrame on every cycle. The request is held high throughout each search to show that it is ignored while the engine is busy.

// File: rtl/clock_repl_pkg.sv
package clock_repl_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SWEEP = 1'b1
  } sweepState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearHere;  // lower flag at hand
    logic pickHere;   // take hand frame as victim
    logic advance;    // move hand forward
  } ctrlStrobes_t;

endpackage

// File: rtl/clock_repl_ctrl.sv
module clock_repl_ctrl
  import clock_repl_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reqValid,
  input  logic         refAtHand,
  output ctrlStrobes_t strobes,
  output logic         busy,
  output logic         done
);

  sweepState_t state, stateNext;

  always_comb begin
    strobes   = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) stateNext = ST_SWEEP;
      end
      ST_SWEEP: begin
        strobes.advance = 1'b1;
        if (refAtHand) begin
          strobes.clearHere = 1'b1;
        end else begin
          strobes.pickHere = 1'b1;
          stateNext        = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strobes.pickHere;
    end
  end

  assign busy = (state == ST_SWEEP);

endmodule

// File: rtl/clock_repl_dp.sv
module clock_repl_dp
  import clock_repl_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accessValid,
  input  logic [IDX_W-1:0] accessFrame,
  input  ctrlStrobes_t     strobes,
  output logic             refAtHand,
  output logic [IDX_W-1:0] victimFrame
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FRAMES - 1);

  logic [NUM_FRAMES-1:0] refBits;
  logic [IDX_W-1:0]      hand;

  for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_frame
    logic hitAccess, atHand, flagQ;
    assign hitAccess = accessValid && (accessFrame == IDX_W'(i));
    assign atHand    = (hand == IDX_W'(i));

    // access notify and load marking win over the sweep clear
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  flagQ <= 1'b0;
      else if (hitAccess || (strobes.pickHere && atHand)) flagQ <= 1'b1;
      else if (strobes.clearHere && atHand)        flagQ <= 1'b0;
    end
    assign refBits[i] = flagQ;
  end

  assign refAtHand = refBits[hand];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hand        <= '0;
      victimFrame <= '0;
    end else begin
      if (strobes.advance) hand <= (hand == LAST_IDX) ? '0 : hand + 1'b1;
      if (strobes.pickHere) victimFrame <= hand;
    end
  end

endmodule

// File: rtl/clock_repl.sv
module clock_repl
  import clock_repl_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accessValid,
  input  logic [IDX_W-1:0] accessFrame,
  input  logic             reqValid,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] victimFrame
);

  ctrlStrobes_t strobes;
  logic         refAtHand;

  clock_repl_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .reqValid  (reqValid),
    .refAtHand (refAtHand),
    .strobes   (strobes),
    .busy      (busy),
    .done      (done)
  );

  clock_repl_dp #(.NUM_FRAMES(NUM_FRAMES)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .accessValid (accessValid),
    .accessFrame (accessFrame),
    .strobes     (strobes),
    .refAtHand   (refAtHand),
    .victimFrame (victimFrame)
  );

endmodule

// File: rtl/clock_repl_chk.sv
module clock_repl_chk #(
  parameter int NUM_FRAMES = 8,
  localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reqValid,
  input logic             busy,
  input logic             done,
  input logic [IDX_W-1:0] victimFrame
);

  int unsigned busyRun;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busyRun <= 0;
    else if (busy) busyRun <= busyRun + 1;
    else           busyRun <= 0;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4

  AST_VICTIM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(victimFrame)); // R4

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R7

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy)); // R7

  AST_REQ_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !busy) |=> busy); // R7

  AST_SWEEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busyRun <= NUM_FRAMES + 1); // R6

  AST_VICTIM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(victimFrame) < NUM_FRAMES)); // R4

endmodule

bind clock_repl clock_repl_chk #(.NUM_FRAMES(NUM_FRAMES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reqValid    (reqValid),
  .busy        (busy),
  .done        (done),
  .victimFrame (victimFrame)
);

// File: tb/clock_repl_tb.sv
module clock_repl_tb;

  localparam int N     = 8;
  localparam int IDX_W = $clog2(N);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             accessValid = 1'b0;
  logic [IDX_W-1:0] accessFrame = '0;
  logic             reqValid = 1'b0;
  logic             busy, done;
  logic [IDX_W-1:0] victimFrame;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model state
  bit mRef[N];
  int mHand = 0;
  bit mBusy = 0;
  bit mDone = 0;
  int mVictim = 0;

  always #2 clk = ~clk;

  clock_repl #(.NUM_FRAMES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .accessValid(accessValid), .accessFrame(accessFrame),
    .reqValid(reqValid), .busy(busy), .done(done), .victimFrame(victimFrame)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 100000);
      finishRun();
    end
  end

  task automatic modelStep(input bit rq, input bit av, input int af);
    mDone = 0;
    if (mBusy) begin
      if (mRef[mHand]) mRef[mHand] = 0;              // R3
      else begin
        mRef[mHand] = 1;                             // R9
        mVictim = mHand; mDone = 1; mBusy = 0;       // R4
      end
      mHand = (mHand + 1) % N;                       // R5
    end else if (rq) mBusy = 1;                      // R7
    if (av && af < N) mRef[af] = 1;                  // R2, R8
  endtask

  task automatic compareAll();
    check(busy == mBusy, "R7 busy", busy, mBusy);
    check(done == mDone, "R4 done", done, mDone);
    check(int'(victimFrame) == mVictim, "R4 victimFrame", victimFrame, mVictim);
  endtask

  task automatic step(input bit rq, input bit av, input int af);
    reqValid    = rq;
    accessValid = av;
    accessFrame = av ? IDX_W'(af) : '0;
    modelStep(rq, av, af);
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic touch(input int f);
    step(0, 1, f);
  endtask

  // request held high through the search; optional access on first inspection
  task automatic runReq(input int expVictim, input int expLat, input int collide, input string tag);
    int lat = 0;
    step(1, 0, 0);
    while (!done && lat < 40) begin
      lat++;
      step(1, (collide >= 0) && (lat == 1), collide);
    end
    check(int'(victimFrame) == expVictim, {tag, " victim"}, victimFrame, expVictim);
    check(lat == expLat, {tag, " latency"}, lat, expLat);
    step(0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 0, "R1 busy", busy, 0);
    check(done == 0, "R1 done", done, 0);
    check(victimFrame == 0, "R1 victimFrame", victimFrame, 0);
    rst_n = 1'b1;
    @(negedge clk);

    runReq(0, 1, -1, "R1 first pick");
    runReq(1, 1, -1, "R5 hand advanced");
    touch(2); touch(3);
    runReq(4, 3, -1, "R3 skip raised");
    for (int f = 0; f < N; f++) touch(f);
    touch(N + 3);   // R2: out of range index changes nothing (accessFrame wraps width)
    runReq(5, N + 1, -1, "R6 all raised FIFO");
    touch(6); touch(7);
    runReq(0, 3, 6, "R5 wrap with R8 collision");
    runReq(1, 1, -1, "R4 clear frame");
    runReq(2, 1, -1, "R4 clear frame");
    runReq(3, 1, -1, "R4 clear frame");
    runReq(4, 1, -1, "R4 clear frame");
    runReq(7, 3, -1, "R8 R9 kept flags skipped");
    repeat (3) step(0, 0, 0);
    finishRun();
  end

endmodule